// File: doc/BRIEF.md
# Receive Queue Host Read Port

This block is the host side of a byte-wide receive queue in a network controller. The receive MAC pushes frame bytes into a 32-entry queue. Each entry carries a marker bit that flags the final byte of a frame. A synchronous host bus pops those bytes, one per read cycle. Once the final byte of a frame has been popped, the block switches to a status phase. In that phase the host must take four bytes of per-frame status before any byte of the next frame appears.

The host may collect the status in two ways. It can keep reading the data address, so the status arrives as if appended to the packet. It can also read a dedicated status address (6). The two may be freely interleaved, because both draw on one shared byte counter. An end-of-frame flag and its output enable accompany packet data reads only. A read-request output, updated on the falling clock edge, tells the host when enough bytes are waiting. An optional burst behaviour holds that request until the queue drains or a frame ends.

Top module: `rx_fifo_host_port`

## Requirements
- R1: After reset, host_rdata is 0, eof_out and eof_oe are 0, rd_req is 0 and underflow is 0.
- R2: A read cycle (host_cs=1, host_rd=1) at address 0 outside the status phase returns queued bytes in write order. The byte appears on host_rdata after the clock edge that samples the read.
- R3: On a packet data read, eof_oe is 1. eof_out is 1 for the byte written with mac_last=1 and 0 for every earlier byte of that frame.
- R4: After the final byte of a frame is read, the next four status reads return frame_stat, sampled at that read's edge, least significant byte first. No byte of the next frame is returned before all four status bytes have been read.
- R5: During the status phase, a read at address 6 returns the next status byte. Reads at addresses 0 and 6 may be mixed and share one four-byte count.
- R6: eof_oe is 0 on status reads (through either address), on empty reads and on cycles with no read.
- R7: A read at address 6 outside the status phase returns 0 and consumes nothing from the queue.
- R8: A data read while the queue is empty and no status is pending returns 0 and sets underflow, which then stays 1 until reset.
- R9: rd_req changes only on the falling clock edge. It asserts once occupancy is at or above rx_wmark.
- R10: With burst_mode=0, rd_req falls at the first falling edge where occupancy is below rx_wmark.
- R11: With burst_mode=1, rd_req stays 1 while occupancy drops below rx_wmark. It falls when the queue is empty, or for at least one falling edge after a frame's final byte is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_we | input | 1 | MAC byte push strobe |
| mac_byte | input | 8 | Byte from the MAC |
| mac_last | input | 1 | Marks the pushed byte as a frame's final byte |
| frame_stat | input | 32 | Status word of the frame being completed |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | 1 = read cycle |
| host_addr | input | 5 | Host register address |
| rx_wmark | input | 6 | Occupancy watermark for rd_req |
| burst_mode | input | 1 | Selects burst-style rd_req release |
| host_rdata | output | 8 | Read data |
| eof_out | output | 1 | End-of-frame flag |
| eof_oe | output | 1 | Output enable of eof_out |
| rd_req | output | 1 | Read data request |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
Suppose the status-phase flag or its byte counter goes wrong. The very next read shows it at the ports: a next-frame byte appears where a status byte belongs, a status byte comes out of order, or eof_oe rises during status. A faulty occupancy count shows up at the next falling edge, as rd_req sitting on the wrong side of the watermark. It also shows as host_rdata disagreeing with the write order. A lost end-of-frame marker hides until the end of that frame, where eof_out stays low and the status bytes never appear.

// File: rtl/rx_fifo_host_port.sv
module rx_fifo_host_port #(
  parameter int DEPTH = 32,
  parameter int AW = 5,
  parameter logic [AW-1:0] DATA_ADDR = 5'd0,
  parameter logic [AW-1:0] STAT_ADDR = 5'd6,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mac_we,
  input  logic [7:0]    mac_byte,
  input  logic          mac_last,
  input  logic [31:0]   frame_stat,
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [CW-1:0] rx_wmark,
  input  logic          burst_mode,
  output logic [7:0]    host_rdata,
  output logic          eof_out,
  output logic          eof_oe,
  output logic          rd_req,
  output logic          underflow
);
  localparam int PW = $clog2(DEPTH);

  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] count;
  logic          in_st, pop_last;
  logic [1:0]    st_idx;
  logic [31:0]   st_word;

  wire       empty   = (count == '0);
  wire       full    = (count == CW'(DEPTH));
  wire       rd_cyc  = host_cs && host_rd;
  wire       data_rd = rd_cyc && (host_addr == DATA_ADDR);
  wire       reg_rd  = rd_cyc && (host_addr == STAT_ADDR);
  wire       stat_rd = in_st && (data_rd || reg_rd);
  wire       pop     = data_rd && !in_st && !empty;
  wire       push    = mac_we && !full;
  wire [8:0] head    = mem[rptr];

  always_ff @(posedge clk)
    if (push) mem[wptr] <= {mac_last, mac_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0; wptr <= '0; count <= '0;
      in_st <= 1'b0; st_idx <= '0; st_word <= '0; pop_last <= 1'b0;
      host_rdata <= '0; eof_out <= 1'b0; eof_oe <= 1'b0; underflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count    <= count + CW'(push) - CW'(pop);
      pop_last <= pop && head[8];
      eof_oe   <= pop;
      eof_out  <= pop && head[8];
      if (pop) begin
        host_rdata <= head[7:0];
        if (head[8]) begin
          in_st   <= 1'b1;
          st_idx  <= '0;
          st_word <= frame_stat;
        end
      end else if (stat_rd) begin
        host_rdata <= st_word[st_idx*8 +: 8];
        st_idx     <= st_idx + 1'b1;
        if (st_idx == 2'd3) in_st <= 1'b0;
      end else if (rd_cyc) begin
        host_rdata <= '0;
        if (data_rd) underflow <= 1'b1;
      end
    end
  end

  wire hit = (count >= rx_wmark);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)          rd_req <= 1'b0;
    else if (!burst_mode) rd_req <= hit;
    else if (rd_req)     rd_req <= !(empty || pop_last);
    else                 rd_req <= hit && !pop_last;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_eof_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head[8]) |=> (eof_out && eof_oe && in_st));
  assert_status_holds_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_st && data_rd) |=> (!eof_oe && rptr == $past(rptr)));
  assert_status_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && st_idx == 2'd3) |=> !in_st);
  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

// File: tb/sim_rx_fifo_host_port.sv
module sim_rx_fifo_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {addr[4:0], data[7:0], eof_oe, eof_out}
  localparam logic [14:0] VEC [NV] = '{
    {5'd0, 8'h11, 1'b1, 1'b0}, {5'd0, 8'h22, 1'b1, 1'b0}, {5'd0, 8'h33, 1'b1, 1'b1},
    {5'd0, 8'hA1, 1'b0, 1'b0}, {5'd6, 8'hB2, 1'b0, 1'b0}, {5'd0, 8'hC3, 1'b0, 1'b0},
    {5'd6, 8'hD4, 1'b0, 1'b0}, {5'd0, 8'h44, 1'b1, 1'b0}, {5'd6, 8'h00, 1'b0, 1'b0},
    {5'd0, 8'h55, 1'b1, 1'b1}, {5'd6, 8'hA1, 1'b0, 1'b0}, {5'd6, 8'hB2, 1'b0, 1'b0},
    {5'd6, 8'hC3, 1'b0, 1'b0}, {5'd6, 8'hD4, 1'b0, 1'b0}, {5'd0, 8'h00, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic mac_we = 0, mac_last = 0, host_cs = 0, host_rd = 0, burst_mode = 0;
  logic [7:0] mac_byte = 0;
  logic [31:0] frame_stat = 32'hD4C3B2A1;
  logic [4:0] host_addr = 0;
  logic [5:0] rx_wmark = 6'd1;
  logic [7:0] host_rdata;
  logic eof_out, eof_oe, rd_req, underflow;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_host_port u0 (.clk(clk), .rst_n(rst_n), .mac_we(mac_we), .mac_byte(mac_byte),
    .mac_last(mac_last), .frame_stat(frame_stat), .host_cs(host_cs), .host_rd(host_rd),
    .host_addr(host_addr), .rx_wmark(rx_wmark), .burst_mode(burst_mode),
    .host_rdata(host_rdata), .eof_out(eof_out), .eof_oe(eof_oe), .rd_req(rd_req),
    .underflow(underflow));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] b, input logic last);
    @(posedge clk); #1 mac_we = 1; mac_byte = b; mac_last = last;
    @(posedge clk); #1 mac_we = 0; mac_last = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(posedge clk); #1 host_cs = 1; host_rd = 1; host_addr = a;
    @(posedge clk); #1 host_cs = 0; host_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", host_rdata, 0);
    chk("R1 eof/oe", {eof_out, eof_oe}, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 underflow", underflow, 0);
    rst_n = 1;

    wr(8'h11, 0); wr(8'h22, 0); wr(8'h33, 1); wr(8'h44, 0); wr(8'h55, 1);
    #6 chk("R9 req at watermark", rd_req, 1);
    // R2 R3 R4 R5 R6 R7 walked from the table
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][14:10]);
      chk($sformatf("R2-R7 vec %0d", i), {host_rdata, eof_oe, eof_out}, VEC[i][9:0]);
    end
    chk("R8 underflow set", underflow, 1);
    #6 chk("R10 req low when empty", rd_req, 0);
    repeat (3) @(posedge clk);
    #1 chk("R8 underflow sticky", underflow, 1);
    chk("R6 oe idle", eof_oe, 0);

    do_reset();
    rx_wmark = 6'd4; burst_mode = 0;
    wr(8'h01, 0); wr(8'h02, 0); wr(8'h03, 0);
    #6 chk("R9 below watermark", rd_req, 0);
    wr(8'h04, 0);
    #6 chk("R9 at watermark", rd_req, 1);
    rd(5'd0);
    #6 chk("R10 nonburst drop", rd_req, 0);

    do_reset();
    burst_mode = 1;
    wr(8'h01, 0); wr(8'h02, 0); wr(8'h03, 0); wr(8'h04, 0);
    #6 chk("R11 burst assert", rd_req, 1);
    rd(5'd0);
    #6 chk("R11 burst hold below watermark", rd_req, 1);
    rd(5'd0); rd(5'd0); rd(5'd0);
    chk("R2 fourth byte", host_rdata, 8'h04);
    #6 chk("R11 burst drop on empty", rd_req, 0);

    do_reset();
    rx_wmark = 6'd1;
    wr(8'h77, 1); wr(8'h88, 0);
    #6 chk("R11 burst assert two bytes", rd_req, 1);
    rd(5'd0);
    chk("R3 single-byte frame eof", {host_rdata, eof_oe, eof_out}, {8'h77, 2'b11});
    #6 chk("R11 drop at frame end", rd_req, 0);
    #10 chk("R11 reassert after frame end", rd_req, 1);
    rd(5'd6);
    chk("R5 status via register", host_rdata, 8'hA1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule